// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is a single-output logic cell built around a small programmable AND array. Each literal input reaches the array in true and in inverted form. Every product term has its own set of enable bits that picks the literals it ANDs together, plus one bit that lets it into the OR. The OR also takes a few side inputs that skip the AND array entirely, for example signals routed in from neighbouring cells. With literals a, b, c and side inputs g, h, the cell can form f = ab + bc' + g + h.

The sum can be sent straight to the output, or sampled by a D flip-flop on the rising clock edge and sent out from there. One configuration bit makes that choice. All configuration lives in one shift register. It is loaded one bit per clock while the configuration enable is high, and the output is held at 0 for that whole time. The flip-flop also has a synchronous clear.

Top module: `fb_sop_cell`

## Requirements
- R1: When rst_n is low, the output goes to 0 at once. Reset clears every configuration bit, which leaves all terms and side inputs disabled and selects combinational mode. After reset, f_out stays 0 for any inputs until new configuration is loaded.
- R2: While cfg_en is high, each rising edge shifts cfg_data into bit 0 of the 31-bit configuration word, so the word is loaded MSB first. The word layout is as follows. Product term k uses bits [7k+6:7k]. Within that field, bit 2i enables literal i in true form, bit 2i+1 enables literal i in inverted form, and bit 6 is the term enable. Side input j is enabled by bit 28+j. Bit 30 selects the output mode: 1 for registered, 0 for combinational.
- R3: While cfg_en is high, f_out is 0 whatever the inputs and configuration are.
- R4: An enabled product term is the AND of its selected literals, and each literal can be used in either polarity. A term that selects both polarities of the same literal is always 0.
- R5: A product term whose term enable is 0 adds 0 to the OR, whatever its literal enables are.
- R6: An enabled product term with no literal selected evaluates to 1.
- R7: An enabled side input is ORed into the sum without passing through the AND array. A disabled side input has no effect.
- R8: In combinational mode, with cfg_en low, f_out equals the current sum of products in the same cycle.
- R9: In registered mode, f_out equals the sum that was sampled at the most recent rising edge. It does not follow input changes between edges.
- R10: When ff_clr is high at a rising edge, the flip-flop loads 0 in place of the sum. ff_clr has no effect between edges.
- R11: While cfg_en is low, the configuration word does not change, whatever cfg_data does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flip-flop and the configuration chain use the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration mode: shift enable and output force |
| cfg_data | input | 1 | Serial configuration bit, MSB first |
| lit_in | input | N_LIT (3) | Literal inputs to the AND array |
| ext_in | input | N_EXT (2) | Side inputs fed directly into the OR |
| ff_clr | input | 1 | Synchronous active-high clear of the output flip-flop |
| f_out | output | 1 | Cell output |

## Verification
The bench attacks the edges of the term logic. It uses an enabled term with no literals, which a design that ANDs from a 0 seed would return as 0. It uses a disabled term whose literal bits are set, which a design that ignores the term enable would let through. It uses a term that selects both polarities of one literal, which must stay 0. It drives cfg_data while the cell is idle, to show that the configuration does not drift. In registered mode, it changes the inputs between edges: a design that left the mode mux on the combinational path would follow those changes at once. It also raises ff_clr between edges, which an asynchronous clear would act on too early. Finally, it bit-checks the field layout with a term placed only in the last slot, so a reversed shift order fails.

// File: rtl/fb_pkg.sv
package fb_pkg;

  // Output path selection held in the top configuration bit.
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  // Bits per product-term field: a true and an inverted enable per literal,
  // plus one term enable.
  function automatic int term_field_bits(input int n_lit);
    return 2 * n_lit + 1;
  endfunction

  // Full configuration word: all term fields, side-input enables, mode bit.
  function automatic int cfg_word_bits(input int n_lit, input int n_pt, input int n_ext);
    return n_pt * term_field_bits(n_lit) + n_ext + 1;
  endfunction

endpackage

// File: rtl/fb_cfg_chain.sv
module fb_cfg_chain #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic [W-1:0] word_q
);

  logic [W-1:0] word_nxt;

  // Next state: shift toward the MSB while enabled, otherwise hold.
  always_comb begin
    if (shift_en) begin
      word_nxt = {word_q[W-2:0], shift_in};
    end else begin
      word_nxt = word_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_nxt;
    end
  end

endmodule

// File: rtl/fb_product_term.sv
module fb_product_term #(
  parameter int N_LIT = 3
) (
  input  logic [N_LIT-1:0]   lit,
  input  logic [2*N_LIT-1:0] sel,
  input  logic               term_en,
  output logic               term
);

  logic [N_LIT-1:0] lit_ok;

  // A literal position passes when every polarity it selects is satisfied.
  // Positions that select nothing pass, so an empty term is the AND identity.
  always_comb begin
    for (int i = 0; i < N_LIT; i++) begin
      lit_ok[i] = (!sel[2*i] || lit[i]) && (!sel[2*i+1] || !lit[i]);
    end
  end

  // A disabled term must not disturb the OR, so it drives 0.
  always_comb begin
    term = term_en && (&lit_ok);
  end

endmodule

// File: rtl/fb_or_plane.sv
module fb_or_plane #(
  parameter int N_PT  = 4,
  parameter int N_EXT = 2
) (
  input  logic [N_PT-1:0]  terms,
  input  logic [N_EXT-1:0] ext_in,
  input  logic [N_EXT-1:0] ext_en,
  output logic             sop
);

  logic [N_EXT-1:0] ext_gated;

  always_comb begin
    ext_gated = ext_in & ext_en;
    sop       = (|terms) || (|ext_gated);
  end

endmodule

// File: rtl/fb_out_stage.sv
module fb_out_stage
  import fb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      hold,
  input  out_mode_e mode,
  input  logic      sop,
  output logic      f_out
);

  logic ff_q;
  logic ff_nxt;
  logic ff_ce;

  // The flip-flop is frozen during configuration. Clear has priority over
  // the clock enable.
  always_comb begin
    ff_ce = !hold;
    if (clr) begin
      ff_nxt = 1'b0;
    end else if (ff_ce) begin
      ff_nxt = sop;
    end else begin
      ff_nxt = ff_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else begin
      ff_q <= ff_nxt;
    end
  end

  // Mode multiplexer, then the force to 0 during configuration.
  always_comb begin
    if (hold) begin
      f_out = 1'b0;
    end else if (mode == OUT_REG) begin
      f_out = ff_q;
    end else begin
      f_out = sop;
    end
  end

endmodule

// File: rtl/fb_sop_cell.sv
module fb_sop_cell
  import fb_pkg::*;
#(
  parameter int N_LIT = 3,
  parameter int N_PT  = 4,
  parameter int N_EXT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_data,
  input  logic [N_LIT-1:0] lit_in,
  input  logic [N_EXT-1:0] ext_in,
  input  logic             ff_clr,
  output logic             f_out
);

  localparam int PT_W   = term_field_bits(N_LIT);
  localparam int CFG_W  = cfg_word_bits(N_LIT, N_PT, N_EXT);
  localparam int EXT_LO = N_PT * PT_W;
  localparam int MODE_B = CFG_W - 1;

  logic [CFG_W-1:0] cfg_q;
  logic [N_PT-1:0]  terms;
  logic [N_EXT-1:0] ext_en;
  logic             sop;
  out_mode_e        mode;

  fb_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .shift_in (cfg_data),
    .word_q   (cfg_q)
  );

  // One product term per field: literal selects first, then the term enable
  // in the field's top bit.
  for (genvar k = 0; k < N_PT; k++) begin : g_term
    fb_product_term #(.N_LIT(N_LIT)) u_term (
      .lit     (lit_in),
      .sel     (cfg_q[k*PT_W +: 2*N_LIT]),
      .term_en (cfg_q[k*PT_W + PT_W - 1]),
      .term    (terms[k])
    );
  end

  always_comb begin
    ext_en = cfg_q[EXT_LO +: N_EXT];
    mode   = out_mode_e'(cfg_q[MODE_B]);
  end

  fb_or_plane #(.N_PT(N_PT), .N_EXT(N_EXT)) u_or (
    .terms  (terms),
    .ext_in (ext_in),
    .ext_en (ext_en),
    .sop    (sop)
  );

  fb_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ff_clr),
    .hold  (cfg_en),
    .mode  (mode),
    .sop   (sop),
    .f_out (f_out)
  );

endmodule

// File: rtl/fb_sop_cell_chk.sv
module fb_sop_cell_chk #(
  parameter int N_EXT = 2,
  parameter int CFG_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_data,
  input logic [N_EXT-1:0] ext_in,
  input logic             ff_clr,
  input logic             f_out,
  input logic [CFG_W-1:0] cfg_word,
  input logic             sop
);

  localparam int EXT_LO = CFG_W - 1 - N_EXT;

  logic             reg_mode;
  logic [N_EXT-1:0] ext_en;

  always_comb begin
    reg_mode = cfg_word[CFG_W-1];
    ext_en   = cfg_word[EXT_LO +: N_EXT];
  end

  assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_word[0] == $past(cfg_data)));

  assert_cfg_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (f_out == 1'b0));

  assert_ext_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !reg_mode && (|(ext_in & ext_en))) |-> f_out);

  assert_comb_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !reg_mode) |-> (f_out == sop));

  assert_reg_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && reg_mode && !ff_clr) |=> (cfg_en || (f_out == $past(sop))));

  assert_sync_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && reg_mode && ff_clr) |=> (cfg_en || (f_out == 1'b0)));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word));

endmodule

bind fb_sop_cell fb_sop_cell_chk #(
  .N_EXT (N_EXT),
  .CFG_W (CFG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_data (cfg_data),
  .ext_in   (ext_in),
  .ff_clr   (ff_clr),
  .f_out    (f_out),
  .cfg_word (cfg_q),
  .sop      (sop)
);

// File: tb/sim_fb_sop_cell.sv
module sim_fb_sop_cell;

  localparam int NL = 3;
  localparam int NE = 2;
  localparam int CW = 31;

  // Table entry: {lit {c,b,a}, ext {h,g}, expected f}, for f = ab + bc' + g + h.
  localparam int NV = 10;
  localparam logic [5:0] VEC [NV] = '{
    {3'b000, 2'b00, 1'b0},
    {3'b001, 2'b00, 1'b0},
    {3'b010, 2'b00, 1'b1},
    {3'b011, 2'b00, 1'b1},
    {3'b100, 2'b00, 1'b0},
    {3'b101, 2'b00, 1'b0},
    {3'b110, 2'b00, 1'b0},
    {3'b111, 2'b00, 1'b1},
    {3'b100, 2'b01, 1'b1},
    {3'b000, 2'b10, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_data;
  logic [NL-1:0] lit_in;
  logic [NE-1:0] ext_in;
  logic          ff_clr;
  logic          f_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fb_sop_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .lit_in(lit_in), .ext_in(ext_in), .ff_clr(ff_clr), .f_out(f_out)
  );

  function automatic logic [CW-1:0] mk_cfg(input logic mode, input logic [1:0] ext,
      input logic [6:0] p3, input logic [6:0] p2, input logic [6:0] p1, input logic [6:0] p0);
    return {mode, ext, p3, p2, p1, p0};
  endfunction

  task automatic chk(input string req, input logic expv);
    total++;
    if (f_out !== expv) begin
      bad++;
      $display("FAIL %s: f_out=%b expected=%b", req, f_out, expv);
    end
  endtask

  task automatic load(input logic [CW-1:0] w);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en   = 1'b1;
      cfg_data = w[i];
    end
    @(negedge clk);
    cfg_en   = 1'b0;
    cfg_data = 1'b0;
  endtask

  task automatic drive(input logic [NL-1:0] l, input logic [NE-1:0] e);
    @(negedge clk);
    lit_in = l;
    ext_in = e;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] ex_comb;
    logic [CW-1:0] ex_reg;
    // PT0 = a&b (bits 0,2 + en), PT1 = b&~c (bits 2,5 + en), both side inputs on.
    ex_comb = mk_cfg(1'b0, 2'b11, 7'b0, 7'b0, 7'b1100100, 7'b1000101);
    ex_reg  = mk_cfg(1'b1, 2'b11, 7'b0, 7'b0, 7'b1100100, 7'b1000101);

    rst_n = 1'b0; cfg_en = 1'b0; cfg_data = 1'b0; ff_clr = 1'b0;
    lit_in = 3'b111; ext_in = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 output low in reset", 1'b0);
    rst_n = 1'b1;
    drive(3'b111, 2'b11);
    chk("R1 cleared config gives 0", 1'b0);
    drive(3'b000, 2'b11);
    chk("R1 cleared config gives 0 (lits low)", 1'b0);

    // Table walk, combinational mode (R4, R7, R8).
    load(ex_comb);
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][5:3], VEC[v][2:1]);
      chk($sformatf("R8 table entry %0d", v), VEC[v][0]);
    end

    // R11: cfg_data toggles while idle; configuration must not move.
    drive(3'b010, 2'b00);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cfg_data = i[0];
    end
    #1;
    chk("R11 config held, f=1", 1'b1);
    drive(3'b000, 2'b00);
    chk("R11 config held, f=0", 1'b0);
    cfg_data = 1'b0;

    // R3: output forced low once configuration starts.
    drive(3'b010, 2'b00);
    chk("R3 precondition f=1", 1'b1);
    @(negedge clk);
    cfg_en = 1'b1;
    #1;
    chk("R3 forced 0 during config", 1'b0);

    // R5: term enable off with literal bits set; side inputs disabled (R7).
    load(mk_cfg(1'b0, 2'b00, 7'b0, 7'b0, 7'b0, 7'b0111111));
    drive(3'b111, 2'b11);
    chk("R5 disabled term gives 0", 1'b0);
    drive(3'b000, 2'b11);
    chk("R7 disabled side inputs ignored", 1'b0);

    // R6: enabled term, no literals.
    load(mk_cfg(1'b0, 2'b00, 7'b0, 7'b0, 7'b0, 7'b1000000));
    drive(3'b000, 2'b00);
    chk("R6 empty term is 1", 1'b1);
    drive(3'b101, 2'b00);
    chk("R6 empty term is 1 (other lits)", 1'b1);

    // R4: both polarities of literal a in one term.
    load(mk_cfg(1'b0, 2'b00, 7'b0, 7'b0, 7'b0, 7'b1000011));
    drive(3'b000, 2'b00);
    chk("R4 a&~a with a=0", 1'b0);
    drive(3'b001, 2'b00);
    chk("R4 a&~a with a=1", 1'b0);

    // R2: layout, only term 3 enabled with inverted c (bit 26 + en bit 27).
    load(mk_cfg(1'b0, 2'b00, 7'b1100000, 7'b0, 7'b0, 7'b0));
    drive(3'b011, 2'b00);
    chk("R2 term3 ~c with c=0", 1'b1);
    drive(3'b100, 2'b00);
    chk("R2 term3 ~c with c=1", 1'b0);

    // R9: registered mode.
    load(ex_reg);
    drive(3'b010, 2'b00);
    @(posedge clk); #1;
    chk("R9 sampled 1 after edge", 1'b1);
    @(negedge clk);
    lit_in = 3'b000;
    #1;
    chk("R9 holds between edges", 1'b1);
    @(posedge clk); #1;
    chk("R9 sampled 0 after edge", 1'b0);

    // R10: synchronous clear.
    drive(3'b010, 2'b00);
    @(posedge clk); #1;
    chk("R10 precondition q=1", 1'b1);
    @(negedge clk);
    ff_clr = 1'b1;
    #1;
    chk("R10 no effect before edge", 1'b1);
    @(posedge clk); #1;
    chk("R10 cleared at edge", 1'b0);
    @(negedge clk);
    ff_clr = 1'b0;
    @(posedge clk); #1;
    chk("R10 resumes sampling", 1'b1);

    // R1: reset in the middle of operation.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset forces 0", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'b010, 2'b11);
    @(posedge clk); #1;
    chk("R1 config cleared by reset", 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule